// File: doc/BRIEF.md
# Cycle-Synchronised Loss Evolution Recorder

This block keeps a per-cycle record of how beam-loss samples develop over time. A stream of loss integrals arrives one sample per accepted transfer. A start-of-cycle pulse arms the recorder. Recording then begins either when the beam-present level goes high (evolution modes) or after a programmed number of samples have passed (capture mode). In the fine evolution and capture modes each sample becomes one buffer entry. In the coarse evolution mode a fixed number of consecutive samples is summed into each entry. The record ends when the buffer length for the mode has been written. It also ends early if the transmission window opens first.

A host reads entries through a request/response port. Reads return data only while the transmission window is high. Outside it, and for addresses beyond the buffer, the response carries an error flag and zero data. The sample input never applies back-pressure: `s_ready` is held high, because the loss stream cannot be paused. On the read side, a request transfers when `rd_valid` and `rd_ready` are both high. Only one response may be outstanding, so `rd_ready` stays low while a response is pending. A response stays valid with stable data until `rsp_ready` accepts it.

Top module: `evo_capture_buffer`

## Requirements
- R1: After reset, `rec_ready` is 0, `rec_count` is 0, `rsp_valid` is 0 and `s_ready` is 1.
- R2: A `soc` pulse clears `rec_ready` and `rec_count` in the next cycle. A sample presented in the same cycle as `soc` is not recorded.
- R3: In fine evolution mode (`cfg_mode`=0, and also for the reserved value 3), the first valid sample seen with `beam_on` high after `soc` is stored at entry 0. The following valid samples fill consecutive entries up to FINE_LEN. Samples taken before `beam_on` is high are not stored.
- R4: In coarse evolution mode (`cfg_mode`=1), entry k holds the sum of valid samples k*AGG to k*AGG+AGG-1, counted from the trigger. Recording stops after COARSE_LEN entries.
- R5: In capture mode (`cfg_mode`=2), the first `cfg_offset` valid samples after `soc` are skipped whatever the state of `beam_on`. The next FINE_LEN samples are stored.
- R6: `rec_ready` rises in the cycle after the last entry of the record is written, with `rec_count` equal to the record length. Later samples change neither the count nor the buffer until the next `soc`.
- R7: If `tx_win` goes high while the recorder is armed or recording, recording stops. `rec_ready` stays 0, and later samples are not written.
- R8: A read accepted while `tx_win` is low returns `rsp_err`=1 and `rsp_data`=0.
- R9: A read accepted while `tx_win` is high returns the stored entry with `rsp_err`=0. An address of DEPTH or above returns `rsp_err`=1 and zero data.
- R10: A read request transfers when `rd_valid` and `rd_ready` are both high. `rsp_valid` is set in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds with stable data and `rd_ready` is 0.
- R11: Cycles with `s_valid` low add nothing to the record.
- R12: The mode and offset are latched at `soc`. Changing `cfg_mode` or `cfg_offset` later has no effect on the current record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soc | input | 1 | Start-of-cycle pulse |
| beam_on | input | 1 | Beam-present level |
| tx_win | input | 1 | Transmission (readout) window level |
| cfg_mode | input | 2 | 0 fine evolution, 1 coarse evolution, 2 capture, 3 as 0 |
| cfg_offset | input | OFF_W | Capture start offset in samples |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, always 1 |
| s_data | input | SAMPLE_W | Loss sample |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | AW | Entry index to read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | ACC_W | Entry value, or 0 on error |
| rsp_err | output | 1 | Read refused (outside window or address out of range) |
| rec_ready | output | 1 | Record for this cycle complete |
| rec_count | output | CNT_W | Entries written this cycle |

## Verification
The assertions check on every cycle that `soc` clears the completion flag and count, and that completion is flagged only with a full count. They also check that nothing is written while the transmission window is open, that error responses carry zero data, and that a stalled response holds steady. The bench scenarios are needed for everything tied to data content. That covers which sample lands in which entry, the coarse sums, the capture offset skip, the latching of configuration at `soc`, and the fact that samples after completion or after an abort leave old entries untouched.

// File: rtl/evo_pkg.sv
package evo_pkg;
  typedef enum logic [1:0] {
    MODE_FINE   = 2'd0,
    MODE_COARSE = 2'd1,
    MODE_CAPT   = 2'd2,
    MODE_RSVD   = 2'd3
  } rec_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REC   = 2'd2,
    ST_DONE  = 2'd3
  } rec_state_e;
endpackage

// File: rtl/evo_accum.sv
module evo_accum #(
  parameter int SAMPLE_W = 20,
  parameter int AGG      = 500,
  parameter int ACC_W    = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                fire,
  input  logic                coarse,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                wr_en,
  output logic [ACC_W-1:0]    wr_data
);
  localparam int AGG_CW = (AGG > 1) ? $clog2(AGG) : 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             last;

  assign sum = acc_q + ACC_W'(s_data);

  generate
    if (AGG > 1) begin : g_agg
      logic [AGG_CW-1:0] cnt_q;
      assign last = !coarse || (cnt_q == AGG_CW'(AGG - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          cnt_q <= '0;
        end else if (fire) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
      end
    end else begin : g_noagg
      assign last = 1'b1;
    end
  endgenerate

  assign wr_en   = fire && last;
  assign wr_data = sum;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
    end else if (fire) begin
      acc_q <= last ? '0 : sum;
    end
  end
endmodule

// File: rtl/evo_cyc_ctrl.sv
module evo_cyc_ctrl
  import evo_pkg::*;
#(
  parameter int FINE_LEN   = 500,
  parameter int COARSE_LEN = 600,
  parameter int OFF_W      = 16,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soc,
  input  logic             beam_on,
  input  logic             tx_win,
  input  logic             s_valid,
  input  logic [1:0]       cfg_mode,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic             wr_en,
  output logic             fire,
  output logic             coarse,
  output logic [CNT_W-1:0] rec_count,
  output logic             rec_ready
);
  rec_state_e       state_q;
  rec_mode_e        mode_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] skip_q;
  logic [CNT_W-1:0] len;
  logic             capt;
  logic             trig;

  assign coarse = (mode_q == MODE_COARSE);
  assign capt   = (mode_q == MODE_CAPT);
  assign len    = coarse ? CNT_W'(COARSE_LEN) : CNT_W'(FINE_LEN);
  assign trig   = capt ? (skip_q == off_q) : beam_on;
  assign fire   = s_valid && !soc && !tx_win &&
                  ((state_q == ST_REC) || ((state_q == ST_ARMED) && trig));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_FINE;
      off_q     <= '0;
      skip_q    <= '0;
      rec_count <= '0;
      rec_ready <= 1'b0;
    end else if (soc) begin
      state_q   <= ST_ARMED;
      mode_q    <= rec_mode_e'(cfg_mode);
      off_q     <= cfg_offset;
      skip_q    <= '0;
      rec_count <= '0;
      rec_ready <= 1'b0;
    end else if (tx_win && (state_q == ST_ARMED || state_q == ST_REC)) begin
      state_q <= ST_IDLE;
    end else begin
      if (state_q == ST_ARMED && s_valid && capt && !trig)
        skip_q <= skip_q + 1'b1;
      if (fire && state_q == ST_ARMED)
        state_q <= ST_REC;
      if (wr_en) begin
        rec_count <= rec_count + 1'b1;
        if (rec_count == len - 1'b1) begin
          state_q   <= ST_DONE;
          rec_ready <= 1'b1;
        end
      end
    end
  end

  a_r2_soc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soc |=> (!rec_ready && rec_count == '0));
  a_r6_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_ready) |-> (rec_count == len));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= len);
  a_r7_no_write_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_win |-> !wr_en);
endmodule

// File: rtl/evo_store.sv
module evo_store #(
  parameter int DEPTH  = 600,
  parameter int DATA_W = 29,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_win,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [AW-1:0]     rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              accept;
  logic              ok;

  assign rd_ready = !rsp_valid;
  assign accept   = rd_valid && rd_ready;
  assign ok       = tx_win && (32'(rd_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !ok;
      rsp_data  <= ok ? mem[rd_addr] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r10_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));
endmodule

// File: rtl/evo_capture_buffer.sv
module evo_capture_buffer
  import evo_pkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int FINE_LEN   = 500,
  parameter int COARSE_LEN = 600,
  parameter int AGG        = 500,
  parameter int OFF_W      = 16,
  localparam int DEPTH = (FINE_LEN > COARSE_LEN) ? FINE_LEN : COARSE_LEN,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ACC_W = SAMPLE_W + ((AGG > 1) ? $clog2(AGG) : 0)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soc,
  input  logic                beam_on,
  input  logic                tx_win,
  input  logic [1:0]          cfg_mode,
  input  logic [OFF_W-1:0]    cfg_offset,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                rd_valid,
  output logic                rd_ready,
  input  logic [AW-1:0]       rd_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ACC_W-1:0]    rsp_data,
  output logic                rsp_err,
  output logic                rec_ready,
  output logic [CNT_W-1:0]    rec_count
);
  logic             fire;
  logic             coarse;
  logic             wr_en;
  logic [ACC_W-1:0] wr_data;

  assign s_ready = 1'b1;

  evo_cyc_ctrl #(
    .FINE_LEN(FINE_LEN), .COARSE_LEN(COARSE_LEN), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soc(soc), .beam_on(beam_on), .tx_win(tx_win),
    .s_valid(s_valid), .cfg_mode(cfg_mode), .cfg_offset(cfg_offset),
    .wr_en(wr_en), .fire(fire), .coarse(coarse),
    .rec_count(rec_count), .rec_ready(rec_ready)
  );

  evo_accum #(
    .SAMPLE_W(SAMPLE_W), .AGG(AGG), .ACC_W(ACC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(soc), .fire(fire), .coarse(coarse),
    .s_data(s_data), .wr_en(wr_en), .wr_data(wr_data)
  );

  evo_store #(
    .DEPTH(DEPTH), .DATA_W(ACC_W), .AW(AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(rec_count[AW-1:0]),
    .wr_data(wr_data), .tx_win(tx_win), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err)
  );
endmodule

// File: tb/evo_capture_buffer_tb.sv
module evo_capture_buffer_tb;
  localparam int SW = 16, FL = 6, CL = 4, AG = 3, OW = 8;
  localparam int AW = 3, CW = 3, DW = SW + 2;

  logic clk = 0, rst_n = 0, soc = 0, beam_on = 0, tx_win = 0;
  logic [1:0] cfg_mode = 0;
  logic [OW-1:0] cfg_offset = 0;
  logic s_valid = 0, s_ready;
  logic [SW-1:0] s_data = 0;
  logic rd_valid = 0, rd_ready, rsp_valid, rsp_ready = 1, rsp_err, rec_ready;
  logic [AW-1:0] rd_addr = 0;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] rec_count;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] rd_d;
  logic rd_e;

  always #2.5 clk = ~clk;

  evo_capture_buffer #(.SAMPLE_W(SW), .FINE_LEN(FL), .COARSE_LEN(CL), .AGG(AG), .OFF_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .soc(soc), .beam_on(beam_on), .tx_win(tx_win),
    .cfg_mode(cfg_mode), .cfg_offset(cfg_offset), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rec_ready(rec_ready), .rec_count(rec_count));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [SW-1:0] v);
    @(negedge clk); s_valid = 1; s_data = v;
    @(negedge clk); s_valid = 0;
  endtask

  task automatic pulse_soc(input logic [1:0] m, input logic [OW-1:0] off);
    @(negedge clk); cfg_mode = m; cfg_offset = off; soc = 1;
    @(negedge clk); soc = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_valid = 1; rd_addr = a;
    @(negedge clk); rd_valid = 0;
    rd_d = rsp_data; rd_e = rsp_err;
    chk(rsp_valid, "R10", rsp_valid, 1);
  endtask

  task automatic t_reset();
    chk(rec_ready == 0, "R1", rec_ready, 0);
    chk(rec_count == 0, "R1", rec_count, 0);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);
    chk(s_ready == 1, "R1", s_ready, 1);
  endtask

  task automatic t_fine();
    pulse_soc(2'd0, 0);
    chk(rec_count == 0 && rec_ready == 0, "R2", rec_count, 0);
    push(16'd900); push(16'd901);
    beam_on = 1;
    for (int i = 0; i < FL; i++) begin
      push(16'(10 + i));
      if (i == 2) @(negedge clk);
    end
    chk(rec_ready == 1, "R6", rec_ready, 1);
    chk(rec_count == FL, "R6", rec_count, FL);
    push(16'd99);
    chk(rec_count == FL, "R6 after done", rec_count, FL);
    rd(0);
    chk(rd_e == 1 && rd_d == 0, "R8", rd_d, 0);
    tx_win = 1;
    for (int i = 0; i < FL; i++) begin
      rd(AW'(i));
      chk(rd_e == 0 && rd_d == DW'(10 + i), "R3", rd_d, 10 + i);
    end
    rd(3'd6);
    chk(rd_e == 1 && rd_d == 0, "R9 range", rd_d, 0);
    tx_win = 0;
  endtask

  task automatic t_coarse();
    beam_on = 1;
    pulse_soc(2'd1, 0);
    cfg_mode = 2'd0;
    for (int i = 1; i <= AG * CL; i++) push(16'(i));
    chk(rec_ready == 1 && rec_count == CL, "R4 R12", rec_count, CL);
    tx_win = 1;
    for (int k = 0; k < CL; k++) begin
      rd(AW'(k));
      chk(rd_d == DW'(9 * k + 6), "R4", rd_d, 9 * k + 6);
    end
    tx_win = 0;
  endtask

  task automatic t_capture();
    beam_on = 0;
    pulse_soc(2'd2, 8'd3);
    cfg_offset = 8'd0;
    for (int i = 0; i < FL + 3; i++) push(16'(100 + i));
    chk(rec_ready == 1 && rec_count == FL, "R5", rec_count, FL);
    tx_win = 1;
    rd(0);
    chk(rd_d == 103, "R5 R12", rd_d, 103);
    rd(3'd5);
    chk(rd_d == 108, "R5", rd_d, 108);
    tx_win = 0;
  endtask

  task automatic t_abort();
    beam_on = 1;
    @(negedge clk); cfg_mode = 0; soc = 1; s_valid = 1; s_data = 16'd77;
    @(negedge clk); soc = 0; s_valid = 0;
    push(16'd50); push(16'd51);
    tx_win = 1;
    push(16'd52); push(16'd53);
    chk(rec_count == 2, "R7", rec_count, 2);
    chk(rec_ready == 0, "R7", rec_ready, 0);
    rd(0);
    chk(rd_d == 50, "R2", rd_d, 50);
    rd(3'd2);
    chk(rd_d == 105, "R7 no write", rd_d, 105);
    @(negedge clk); s_valid = 0;
    tx_win = 0;
  endtask

  task automatic t_stall();
    tx_win = 1;
    @(negedge clk); rsp_ready = 0; rd_valid = 1; rd_addr = 1;
    @(negedge clk); rd_valid = 0;
    rd_d = rsp_data;
    @(negedge clk); @(negedge clk);
    chk(rsp_valid == 1 && rd_ready == 0, "R10 hold", rsp_valid, 1);
    chk(rsp_data == rd_d && rd_d == 51, "R10 stable", rsp_data, 51);
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 0 && rd_ready == 1, "R10 release", rsp_valid, 0);
    tx_win = 0;
  endtask

  task automatic t_idle_valid();
    beam_on = 1;
    pulse_soc(2'd0, 0);
    repeat (4) @(negedge clk);
    chk(rec_count == 0, "R11", rec_count, 0);
    push(16'd7);
    chk(rec_count == 1, "R11", rec_count, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fine();
    t_coarse();
    t_capture();
    t_abort();
    t_stall();
    t_idle_valid();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule